// File: doc/BRIEF.md
# Adaptive Three-Level Motion Search Controller

This block steers a fast block-matching motion search for one 16x16 macroblock. A search starts from a predicted center supplied by logic outside the block, and the block first asks for the matching cost at that predicted point. It compares that cost with two programmable thresholds to choose how wide to search. A small cost keeps a tight 5x5 area around the prediction. A moderate cost opens a 7x7 area. A large cost means the prediction is not trusted, and the search then spans the whole window from the origin.

Each round, the controller sends a center and a grid spacing to an external cost array. The array evaluates the nine points of the 3x3 grid and returns nine costs. The controller moves the center to the cheapest legal point and roughly halves the spacing. The search ends after the round run at spacing 1. It can also end earlier, when the best cost of a round falls below an all-zero-residual threshold. The final vector, its cost and an early-stop flag are then presented with a one-cycle done pulse.

Top module: `srch_top`

## Requirements
- R1: After reset, `busy`, `done` and `reqValid` are all low.
- R2: After `start`, the first request has `reqStep` = 0 and sits at the predicted center. Only cost slot 4 of its answer is used, as the probe cost.
- R3: The probe cost sets the starting spacing. Below `thrLow` gives spacing 2 around the predicted center. Otherwise, below `thrHigh` gives spacing 3 around the predicted center. Otherwise the spacing is 8 and the center moves to (0,0).
- R4: After each round the spacing becomes ceil(spacing/2), which gives the sequences 2,1 / 3,2,1 / 8,4,2,1. The search ends after the round with spacing 1.
- R5: `costs` carries point k in bits [16k+15:16k], with k = 3*(dy+1)+(dx+1) and the point at (reqX+dx*reqStep, reqY+dy*reqStep). The new center is the lowest-cost point. On a tie the current center (k=4) wins first, then the lowest k.
- R6: A point with either coordinate outside -15..+15 is never chosen, whatever cost is returned for it.
- R7: When the lowest cost of a round is strictly below `thrZero`, the search ends after that round with `earlyStop` = 1. This also applies when it is the spacing-1 round. Otherwise `earlyStop` = 0.
- R8: `done` is high for exactly one cycle. `mvX`, `mvY` and `mvCost` give the final center and its round-minimum cost, and they hold until the next `start`. The vector stays within -15..+15.
- R9: `reqValid` stays high with `reqX`, `reqY` and `reqStep` stable until `reqReady`. A `costValid` pulse while a request is still pending is ignored.
- R10: A predicted coordinate outside -15..+15 is clamped to the nearest bound before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| predX | input | 6 | Predicted center X, signed |
| predY | input | 6 | Predicted center Y, signed |
| thrLow | input | 16 | Probe cost limit for the 5x5 level |
| thrHigh | input | 16 | Probe cost limit for the 7x7 level |
| thrZero | input | 16 | All-zero early-stop cost limit |
| reqValid | output | 1 | Cost request pending |
| reqReady | input | 1 | Cost array accepts the request |
| reqX | output | 6 | Requested grid center X, signed |
| reqY | output | 6 | Requested grid center Y, signed |
| reqStep | output | 4 | Requested grid spacing (0 = probe) |
| costValid | input | 1 | Nine costs are present |
| costs | input | 144 | Nine packed 16-bit costs |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| mvX | output | 6 | Final vector X, signed |
| mvY | output | 6 | Final vector Y, signed |
| mvCost | output | 16 | Cost of the final vector |
| earlyStop | output | 1 | Search ended on the all-zero test |

## Verification
The all-zero early stop and the normal end after the spacing-1 round can both happen on the same cost return. The bench provokes this with a 5x5 search whose zero threshold sits one above the exact-match cost. In that case only the final round can pass the test. The bench requires a single done pulse, the exact-match vector, the spacing trail 2,1 and the early-stop flag set. A second overlap comes from tie breaking and window masking acting on the same round. Near a corner of the window the cost array returns zero for out-of-window points, and the result must still be the first legal point in raster order.

// File: rtl/srch_pkg.sv
`timescale 1ns/1ps
package srch_pkg;
  typedef struct packed {
    logic init;       // latch prediction and thresholds, begin probe
    logic takeProbe;  // probe cost present: pick level
    logic takeRound;  // round costs present: move center, shrink step
  } strobeT;
endpackage

// File: rtl/srch_dp.sv
`timescale 1ns/1ps
module srch_dp import srch_pkg::*; #(
  parameter int MVW = 6,
  parameter int CW = 16,
  parameter int STEPW = 4,
  parameter int SR = 15,
  parameter int STEP_FINE = 2,
  parameter int STEP_MID = 3,
  parameter int STEP_FULL = 8
) (
  input  logic clk,
  input  logic rstN,
  input  strobeT strb,
  input  logic signed [MVW-1:0] predX,
  input  logic signed [MVW-1:0] predY,
  input  logic [CW-1:0] thrLow,
  input  logic [CW-1:0] thrHigh,
  input  logic [CW-1:0] thrZero,
  input  logic [9*CW-1:0] costs,
  output logic signed [MVW-1:0] centerX,
  output logic signed [MVW-1:0] centerY,
  output logic [STEPW-1:0] step,
  output logic [CW-1:0] bestCost,
  output logic earlyStop,
  output logic stopNow
);
  localparam int EXW = MVW + 1;

  logic [CW-1:0] thrLowQ, thrHighQ, thrZeroQ;
  logic signed [EXW-1:0] cx, cy, stExt;
  logic signed [EXW-1:0] candX [9];
  logic signed [EXW-1:0] candY [9];
  logic inWin [9];
  logic [3:0] bestIdx;
  logic [CW-1:0] minC;
  logic zeroHit;
  logic [CW-1:0] probeCost;

  function automatic logic signed [MVW-1:0] clampMv(input logic signed [MVW-1:0] v);
    if (v > SR) return MVW'(SR);
    if (v < -SR) return -MVW'(SR);
    return v;
  endfunction

  assign cx = {centerX[MVW-1], centerX};
  assign cy = {centerY[MVW-1], centerY};
  assign stExt = $signed({{(EXW-STEPW){1'b0}}, step});

  for (genvar k = 0; k < 9; k++) begin : g_cand
    localparam int DX = k % 3 - 1;
    localparam int DY = k / 3 - 1;
    if (DX < 0) begin : g_xm
      assign candX[k] = cx - stExt;
    end else if (DX > 0) begin : g_xp
      assign candX[k] = cx + stExt;
    end else begin : g_x0
      assign candX[k] = cx;
    end
    if (DY < 0) begin : g_ym
      assign candY[k] = cy - stExt;
    end else if (DY > 0) begin : g_yp
      assign candY[k] = cy + stExt;
    end else begin : g_y0
      assign candY[k] = cy;
    end
    assign inWin[k] = (candX[k] >= -SR) && (candX[k] <= SR) &&
                      (candY[k] >= -SR) && (candY[k] <= SR);
  end

  // Center seeds the minimum, so it wins ties; strict compare keeps raster order.
  always_comb begin
    bestIdx = 4'd4;
    minC = costs[4*CW +: CW];
    for (int k = 0; k < 9; k++) begin
      if (k != 4 && inWin[k] && costs[k*CW +: CW] < minC) begin
        minC = costs[k*CW +: CW];
        bestIdx = 4'(k);
      end
    end
  end

  assign probeCost = costs[4*CW +: CW];
  assign zeroHit = minC < thrZeroQ;
  assign stopNow = (step == STEPW'(1)) || zeroHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      centerX <= '0;
      centerY <= '0;
      step <= '0;
      bestCost <= '0;
      earlyStop <= 1'b0;
      thrLowQ <= '0;
      thrHighQ <= '0;
      thrZeroQ <= '0;
    end else if (strb.init) begin
      centerX <= clampMv(predX);
      centerY <= clampMv(predY);
      step <= '0;
      earlyStop <= 1'b0;
      thrLowQ <= thrLow;
      thrHighQ <= thrHigh;
      thrZeroQ <= thrZero;
    end else if (strb.takeProbe) begin
      if (probeCost < thrLowQ) begin
        step <= STEPW'(STEP_FINE);
      end else if (probeCost < thrHighQ) begin
        step <= STEPW'(STEP_MID);
      end else begin
        step <= STEPW'(STEP_FULL);
        centerX <= '0;
        centerY <= '0;
      end
    end else if (strb.takeRound) begin
      centerX <= candX[bestIdx][MVW-1:0];
      centerY <= candY[bestIdx][MVW-1:0];
      bestCost <= minC;
      step <= STEPW'(({1'b0, step} + 1'b1) >> 1);
      earlyStop <= zeroHit;
    end
  end

  // R8: the center, which is also the reported vector, never leaves the window
  a_r8_mv_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (centerX <= SR) && (centerX >= -SR) && (centerY <= SR) && (centerY >= -SR));

  // R6: the chosen point of a round lies inside the window
  a_r6_pick_in_window: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRound |-> inWin[bestIdx]);

  // R5: the chosen cost never exceeds the cost of staying put
  a_r5_not_worse_than_center: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRound |-> minC <= costs[4*CW +: CW]);

  // R4: a round at spacing above 1 leaves a smaller, nonzero spacing
  a_r4_step_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeRound && step > STEPW'(1)) |=> (step < $past(step)) && (step != '0));
endmodule

// File: rtl/srch_ctrl.sv
`timescale 1ns/1ps
module srch_ctrl import srch_pkg::*; (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic reqReady,
  input  logic costValid,
  input  logic stopNow,
  output strobeT strb,
  output logic reqValid,
  output logic busy,
  output logic done
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} stateT;
  stateT state, stateNxt;
  logic probing, probingNxt;

  always_comb begin
    stateNxt = state;
    probingNxt = probing;
    strb = '0;
    case (state)
      S_IDLE: if (start) begin
        strb.init = 1'b1;
        probingNxt = 1'b1;
        stateNxt = S_REQ;
      end
      S_REQ: if (reqReady) stateNxt = S_WAIT;
      S_WAIT: if (costValid) begin
        if (probing) begin
          strb.takeProbe = 1'b1;
          probingNxt = 1'b0;
          stateNxt = S_REQ;
        end else begin
          strb.takeRound = 1'b1;
          stateNxt = stopNow ? S_DONE : S_REQ;
        end
      end
      S_DONE: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      probing <= 1'b0;
    end else begin
      state <= stateNxt;
      probing <= probingNxt;
    end
  end

  assign reqValid = (state == S_REQ);
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: costs are only consumed after the request was accepted
  a_r9_costs_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeProbe || strb.takeRound) |-> !reqValid);

  // R1/R2: a start from idle always opens with a request
  a_r2_start_requests: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> reqValid);
endmodule

// File: rtl/srch_top.sv
`timescale 1ns/1ps
module srch_top import srch_pkg::*; #(
  parameter int MVW = 6,
  parameter int CW = 16,
  parameter int STEPW = 4,
  parameter int SR = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic signed [MVW-1:0] predX,
  input  logic signed [MVW-1:0] predY,
  input  logic [CW-1:0] thrLow,
  input  logic [CW-1:0] thrHigh,
  input  logic [CW-1:0] thrZero,
  output logic reqValid,
  input  logic reqReady,
  output logic signed [MVW-1:0] reqX,
  output logic signed [MVW-1:0] reqY,
  output logic [STEPW-1:0] reqStep,
  input  logic costValid,
  input  logic [9*CW-1:0] costs,
  output logic busy,
  output logic done,
  output logic signed [MVW-1:0] mvX,
  output logic signed [MVW-1:0] mvY,
  output logic [CW-1:0] mvCost,
  output logic earlyStop
);
  strobeT strb;
  logic stopNow;
  logic signed [MVW-1:0] centerX, centerY;
  logic [STEPW-1:0] step;

  srch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqReady(reqReady),
    .costValid(costValid), .stopNow(stopNow), .strb(strb),
    .reqValid(reqValid), .busy(busy), .done(done)
  );

  srch_dp #(.MVW(MVW), .CW(CW), .STEPW(STEPW), .SR(SR)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .predX(predX), .predY(predY),
    .thrLow(thrLow), .thrHigh(thrHigh), .thrZero(thrZero), .costs(costs),
    .centerX(centerX), .centerY(centerY), .step(step), .bestCost(mvCost),
    .earlyStop(earlyStop), .stopNow(stopNow)
  );

  assign reqX = centerX;
  assign reqY = centerY;
  assign reqStep = step;
  assign mvX = centerX;
  assign mvY = centerY;

  // R9: a pending request holds its fields until accepted
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid && $stable(reqX) && $stable(reqY) && $stable(reqStep));
endmodule

// File: tb/sim_srch_top.sv
`timescale 1ns/1ps
module sim_srch_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signed [5:0] predX = '0, predY = '0;
  logic [15:0] thrLow = 16'd50, thrHigh = 16'd500, thrZero = 16'd0;
  logic reqValid, reqReady = 1'b0;
  logic signed [5:0] reqX, reqY;
  logic [3:0] reqStep;
  logic costValid = 1'b0;
  logic [143:0] costs = '0;
  logic busy, done, earlyStop;
  logic signed [5:0] mvX, mvY;
  logic [15:0] mvCost;

  int nChecks = 0, nFails = 0;
  int tx, ty, base, probeCost, reqDelay;
  bit flatMode, spurious, holdBad;
  int stepSig, stepCnt, firstX, firstY;

  always #5 clk = ~clk;

  srch_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .predX(predX), .predY(predY),
    .thrLow(thrLow), .thrHigh(thrHigh), .thrZero(thrZero),
    .reqValid(reqValid), .reqReady(reqReady), .reqX(reqX), .reqY(reqY),
    .reqStep(reqStep), .costValid(costValid), .costs(costs), .busy(busy),
    .done(done), .mvX(mvX), .mvY(mvY), .mvCost(mvCost), .earlyStop(earlyStop)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int costAt(input int cx, input int cy, input int st, input int k);
    int px, py;
    px = cx + (k % 3 - 1) * st;
    py = cy + (k / 3 - 1) * st;
    if (iabs(px) > 15 || iabs(py) > 15) return 0;   // out of window: tempting zero
    if (st == 0) return probeCost;
    if (flatMode) return (k == 4) ? 60 : 50;
    return base + 4 * (iabs(px - tx) + iabs(py - ty));
  endfunction

  // Cost array model: accepts requests, logs them, answers with nine costs
  initial begin
    forever begin
      @(negedge clk);
      if (reqValid) begin
        int cx, cy, st;
        cx = int'(reqX); cy = int'(reqY); st = int'(reqStep);
        if (stepCnt == 0) begin firstX = cx; firstY = cy; end
        stepSig = stepSig * 10 + st;
        stepCnt++;
        for (int d = 0; d < reqDelay; d++) begin
          if (spurious && d == 0) begin costs = '0; costValid = 1'b1; end
          @(negedge clk);
          costValid = 1'b0;
          if (!reqValid || int'(reqX) != cx || int'(reqY) != cy || int'(reqStep) != st)
            holdBad = 1'b1;
        end
        reqReady = 1'b1;
        @(negedge clk);
        reqReady = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 9; k++) costs[k*16 +: 16] = 16'(costAt(cx, cy, st, k));
        costValid = 1'b1;
        @(negedge clk);
        costValid = 1'b0;
      end
    end
  end

  task automatic runSearch(input string nm, input int px, input int py, input int pc,
                           input int zt, input int expX, input int expY, input int expC,
                           input bit expE, input int expSig);
    bit seen;
    int hx;
    predX = 6'(px); predY = 6'(py); probeCost = pc; thrZero = 16'(zt);
    stepSig = 0; stepCnt = 0; holdBad = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, {nm, " R8 done seen"}, int'(seen), 1);
    check(int'(mvX) == expX, {nm, " R5 mvX"}, int'(mvX), expX);
    check(int'(mvY) == expY, {nm, " R5 mvY"}, int'(mvY), expY);
    check(int'(mvCost) == expC, {nm, " R8 mvCost"}, int'(mvCost), expC);
    check(earlyStop == expE, {nm, " R7 earlyStop"}, int'(earlyStop), int'(expE));
    check(stepSig == expSig, {nm, " R3 R4 step trail"}, stepSig, expSig);
    check(!holdBad, {nm, " R9 request held"}, int'(holdBad), 0);
    hx = int'(mvX);
    @(negedge clk);
    check(!done && !busy, {nm, " R8 done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'(mvX) == hx, {nm, " R8 vector held"}, int'(mvX), hx);
  endtask

  task automatic tReset();
    check(!busy, "R1 busy after reset", int'(busy), 0);
    check(!done, "R1 done after reset", int'(done), 0);
    check(!reqValid, "R1 reqValid after reset", int'(reqValid), 0);
  endtask

  task automatic tFullRange();
    flatMode = 0; tx = 5; ty = -3; base = 100; reqDelay = 1; spurious = 0;
    runSearch("full", 3, 3, 1000, 0, 5, -3, 100, 1'b0, 8421);
    check(firstX == 3 && firstY == 3, "R2 probe at predicted center", firstX, 3);
  endtask

  task automatic tFine();
    flatMode = 0; tx = 3; ty = 1; base = 100; reqDelay = 0; spurious = 0;
    runSearch("fine", 2, 2, 10, 0, 3, 1, 100, 1'b0, 21);
  endtask

  task automatic tMidClamp();
    flatMode = 0; tx = -14; ty = 5; base = 100; reqDelay = 3; spurious = 1;
    runSearch("mid", -20, 7, 100, 0, -14, 5, 100, 1'b0, 321);
    check(firstX == -15, "R10 predicted X clamped", firstX, -15);
    check(firstY == 7, "R10 in-range Y kept", firstY, 7);
  endtask

  task automatic tEarly();
    flatMode = 0; tx = 5; ty = -3; base = 100; reqDelay = 0; spurious = 0;
    runSearch("early", 0, 0, 1000, 200, 8, 0, 124, 1'b1, 8);
  endtask

  task automatic tEarlyAndLast();
    flatMode = 0; tx = 3; ty = 1; base = 100; reqDelay = 0; spurious = 0;
    runSearch("early+last", 2, 2, 10, 101, 3, 1, 100, 1'b1, 21);
  endtask

  task automatic tTies();
    flatMode = 1; reqDelay = 2; spurious = 1;
    runSearch("tie raster", 0, 0, 10, 0, -3, -3, 50, 1'b0, 21);
    runSearch("tie corner R6", -15, -15, 10, 0, -14, -15, 50, 1'b0, 21);
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFullRange();
    tFine();
    tMidClamp();
    tEarly();
    tEarlyAndLast();
    tTies();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule